// File: doc/BRIEF.md
# USB PD Source Capability Selector

This block receives the power objects a USB PD source advertises and chooses the one that best serves a requested voltage and a requested power. The objects arrive one per clock on a streaming interface with a valid strobe and a last marker. Each object is either a Fixed object or a programmable (PPS) object, and carries a nominal voltage, a minimum and maximum voltage (used only by PPS objects) and a maximum current. Voltages are in 10 mV units, currents in 10 mA units, and the requested power is in milliwatts.

The requested voltage comes from a 3-bit select code. The requested power is a plain number. Once the last object of a list has been accepted, the block reports three things: whether any object matched, the zero-based index of the chosen object, and the voltage the sink should ask for. The select code and the requested power must stay stable while a list is being streamed. A new list may begin in the cycle right after the previous list ends.

Top module: `pdo_cap_select`

## Requirements
- R1: A Fixed object (type bit 0) matches when its nominal voltage equals the requested voltage and nominal voltage × current (units of 0.1 mW) is at least 10 × the requested power in mW, with equality counting as a match. The result then gives that object's index and its voltage.
- R2: A PPS object (type bit 1) passes the voltage test when minimum ≤ requested voltage ≤ maximum. Both bounds are inclusive.
- R3: A PPS object passes the power test when its nominal voltage × current is at least 10 × the requested power. The requested voltage plays no part in this test.
- R4: If PPS and Fixed objects both match, the chosen object is a PPS object.
- R5: Among the matching PPS objects, the one with the lowest nominal voltage is chosen. When candidates are equal, the lower index wins.
- R6: If nothing matches, the result gives match=0, index 0, and the nominal voltage of the first object in the list.
- R7: Select codes 0 to 7 map to 500, 900, 1500, 2000, 430, 860, 1290 and 1720 (10 mV units). A PPS match reports the requested voltage as its result voltage.
- R8: For codes 4 to 7 (top bit set), a Fixed object never matches, even when its voltage equals the requested voltage.
- R9: res_valid is high for exactly the one cycle that follows the clock edge where an object with valid=1 and last=1 is accepted. Apart from that it is low, and the result fields hold their values.
- R10: Only the first 7 objects of a list are considered. Any later objects in the same list are ignored.
- R11: While reset is applied, and just after it, res_valid, res_match, res_idx and res_volt are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_code | input | 3 | Requested-voltage select code |
| req_pw | input | 17 | Requested power, mW |
| obj_valid | input | 1 | An object is present this cycle |
| obj_last | input | 1 | This object is the last one in the list |
| obj_is_pps | input | 1 | Object type: 0 for Fixed, 1 for PPS |
| obj_v_nom | input | 12 | Nominal voltage, 10 mV units |
| obj_v_min | input | 12 | PPS minimum voltage, 10 mV units |
| obj_v_max | input | 12 | PPS maximum voltage, 10 mV units |
| obj_curr | input | 10 | Maximum current, 10 mA units |
| res_valid | output | 1 | Result strobe |
| res_match | output | 1 | An object matched |
| res_idx | output | 3 | Index of the chosen object |
| res_volt | output | 12 | Voltage to request, 10 mV units |

## Verification
The only latency is one register. The result of a list is due in the cycle after the edge that accepts its last object, and res_valid must be low in every other cycle. The bench drives inputs on the falling edge. In the same falling edge, before it drives anything, it compares every output with a reference. The reference computed its expectation when the previous object was driven. So the strobe is checked in every cycle, and the result fields are checked in exactly the cycle they are due. Each list is followed by at least one idle cycle, which confirms that the strobe drops and the fields hold.

// File: rtl/pdo_sel_pkg.sv
// Package: shared type and select-code table for the capability selector.
// Assumes callers truncate the 16-bit table value to their voltage width.
package pdo_sel_pkg;

    typedef enum logic {
        KIND_FIXED = 1'b0,
        KIND_PPS   = 1'b1
    } obj_kind_e;

    // Map the 3-bit select code to a requested voltage in 10 mV units.
    function automatic logic [15:0] code_to_cv(input logic [2:0] code);
        logic [15:0] v;
        case (code)
            3'd0:    v = 16'd500;
            3'd1:    v = 16'd900;
            3'd2:    v = 16'd1500;
            3'd3:    v = 16'd2000;
            3'd4:    v = 16'd430;
            3'd5:    v = 16'd860;
            3'd6:    v = 16'd1290;
            default: v = 16'd1720;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pdo_obj_match.sv
// Module: combinational match test for one power object.
// Applies the voltage test and the power test to a Fixed or PPS object.
// Power compares V(10mV)*I(10mA) in 0.1 mW against 10*P(mW), using a full-width product.
// Assumes all inputs are stable within the cycle; has no state.
module pdo_obj_match
    import pdo_sel_pkg::*;
#(
    parameter int VW = 12,
    parameter int CW = 10,
    parameter int PW = 17
) (
    input  obj_kind_e         kind,
    input  logic [VW-1:0]     v_nom,
    input  logic [VW-1:0]     v_min,
    input  logic [VW-1:0]     v_max,
    input  logic [CW-1:0]     curr,
    input  logic [VW-1:0]     tgt_v,
    input  logic              pps_only,
    input  logic [PW-1:0]     req_pw,
    output logic              hit_fix,
    output logic              hit_pps
);
    localparam int PROD_W = VW + CW;
    localparam int NEED_W = PW + 4;
    localparam int CMP_W  = (PROD_W > NEED_W) ? PROD_W : NEED_W;

    logic [CMP_W-1:0] avail;
    logic [CMP_W-1:0] need;
    logic             pwr_ok;
    logic             in_window;

    // Compute available and needed power on a common width.
    always_comb begin
        avail  = CMP_W'(v_nom) * CMP_W'(curr);
        need   = CMP_W'(req_pw) * CMP_W'(10);
        pwr_ok = (avail >= need);
    end

    // Apply the per-kind voltage test, then gate with the power test.
    always_comb begin
        in_window = (v_min <= tgt_v) && (tgt_v <= v_max);
        hit_fix   = (kind == KIND_FIXED) && !pps_only && (v_nom == tgt_v) && pwr_ok;
        hit_pps   = (kind == KIND_PPS) && in_window && pwr_ok;
    end

endmodule

// File: rtl/pdo_best_track.sv
// Module: running best-candidate tracker for one object list.
// Keeps the best PPS candidate (lowest nominal voltage, earliest on equal values),
// the first Fixed candidate, the first object's voltage and an object count.
// Exposes the outcome that includes the current object, so the final object
// needs no extra cycle. State clears when a list ends.
// Assumes hit inputs belong to the object presented this cycle.
module pdo_best_track #(
    parameter int VW      = 12,
    parameter int MAX_OBJ = 7,
    parameter int IDX_W   = (MAX_OBJ > 1) ? $clog2(MAX_OBJ) : 1,
    parameter int CNT_W   = $clog2(MAX_OBJ + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              last,
    input  logic              hit_fix,
    input  logic              hit_pps,
    input  logic [VW-1:0]     v_nom,
    output logic              fin_match,
    output logic [IDX_W-1:0]  fin_idx,
    output logic [VW-1:0]     fin_first_v
);
    logic [CNT_W-1:0] cnt,      n_cnt;
    logic             pps_have, n_pps_have;
    logic [IDX_W-1:0] pps_idx,  n_pps_idx;
    logic [VW-1:0]    pps_v,    n_pps_v;
    logic             fix_have, n_fix_have;
    logic [IDX_W-1:0] fix_idx,  n_fix_idx;
    logic [VW-1:0]    first_v,  n_first_v;
    logic             in_cap;

    // Fold the current object into the running candidates.
    always_comb begin
        n_cnt      = cnt;
        n_pps_have = pps_have;
        n_pps_idx  = pps_idx;
        n_pps_v    = pps_v;
        n_fix_have = fix_have;
        n_fix_idx  = fix_idx;
        n_first_v  = first_v;
        in_cap     = (cnt < CNT_W'(MAX_OBJ));
        if (take && in_cap) begin
            if (cnt == '0) begin
                n_first_v = v_nom;
            end
            if (hit_pps && (!pps_have || (v_nom < pps_v))) begin
                n_pps_have = 1'b1;
                n_pps_idx  = IDX_W'(cnt);
                n_pps_v    = v_nom;
            end
            if (hit_fix && !fix_have) begin
                n_fix_have = 1'b1;
                n_fix_idx  = IDX_W'(cnt);
            end
            n_cnt = cnt + 1'b1;
        end
    end

    // Resolve priority: PPS first, then Fixed, else fallback index 0.
    always_comb begin
        fin_match   = n_pps_have || n_fix_have;
        fin_first_v = n_first_v;
        if (n_pps_have) begin
            fin_idx = n_pps_idx;
        end else if (n_fix_have) begin
            fin_idx = n_fix_idx;
        end else begin
            fin_idx = '0;
        end
    end

    // Hold the running candidates; clear them at the end of each list.
    always_ff @(posedge clk) begin
        if (!rst_n || (take && last)) begin
            cnt      <= '0;
            pps_have <= 1'b0;
            pps_idx  <= '0;
            pps_v    <= '0;
            fix_have <= 1'b0;
            fix_idx  <= '0;
            first_v  <= '0;
        end else begin
            cnt      <= n_cnt;
            pps_have <= n_pps_have;
            pps_idx  <= n_pps_idx;
            pps_v    <= n_pps_v;
            fix_have <= n_fix_have;
            fix_idx  <= n_fix_idx;
            first_v  <= n_first_v;
        end
    end

endmodule

// File: rtl/pdo_cap_select.sv
// Module: top of the source capability selector.
// Decodes the select code, tests each streamed object and tracks the best one.
// Registers the result one cycle after the last object.
// Assumes sel_code and req_pw are stable for the duration of a list.
module pdo_cap_select
    import pdo_sel_pkg::*;
#(
    parameter int VW      = 12,
    parameter int CW      = 10,
    parameter int PW      = 17,
    parameter int MAX_OBJ = 7,
    parameter int IDX_W   = (MAX_OBJ > 1) ? $clog2(MAX_OBJ) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        sel_code,
    input  logic [PW-1:0]     req_pw,
    input  logic              obj_valid,
    input  logic              obj_last,
    input  logic              obj_is_pps,
    input  logic [VW-1:0]     obj_v_nom,
    input  logic [VW-1:0]     obj_v_min,
    input  logic [VW-1:0]     obj_v_max,
    input  logic [CW-1:0]     obj_curr,
    output logic              res_valid,
    output logic              res_match,
    output logic [IDX_W-1:0]  res_idx,
    output logic [VW-1:0]     res_volt
);
    logic [VW-1:0]    tgt_v;
    logic             pps_only;
    logic             hit_fix;
    logic             hit_pps;
    logic             fin_match;
    logic [IDX_W-1:0] fin_idx;
    logic [VW-1:0]    fin_first_v;
    logic             list_end;

    // Decode the requested voltage and the PPS-only restriction.
    always_comb begin
        tgt_v    = VW'(code_to_cv(sel_code));
        pps_only = sel_code[2];
        list_end = obj_valid && obj_last;
    end

    pdo_obj_match #(.VW(VW), .CW(CW), .PW(PW)) u_match (
        .kind     (obj_kind_e'(obj_is_pps)),
        .v_nom    (obj_v_nom),
        .v_min    (obj_v_min),
        .v_max    (obj_v_max),
        .curr     (obj_curr),
        .tgt_v    (tgt_v),
        .pps_only (pps_only),
        .req_pw   (req_pw),
        .hit_fix  (hit_fix),
        .hit_pps  (hit_pps)
    );

    pdo_best_track #(.VW(VW), .MAX_OBJ(MAX_OBJ), .IDX_W(IDX_W)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (obj_valid),
        .last        (obj_last),
        .hit_fix     (hit_fix),
        .hit_pps     (hit_pps),
        .v_nom       (obj_v_nom),
        .fin_match   (fin_match),
        .fin_idx     (fin_idx),
        .fin_first_v (fin_first_v)
    );

    // Register the outcome at list end; fields hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_match <= 1'b0;
            res_idx   <= '0;
            res_volt  <= '0;
        end else begin
            res_valid <= list_end;
            if (list_end) begin
                res_match <= fin_match;
                res_idx   <= fin_idx;
                res_volt  <= fin_match ? tgt_v : fin_first_v;
            end
        end
    end

endmodule

// File: rtl/pdo_cap_select_chk.sv
// Module: property checker for pdo_cap_select, attached by bind.
// Independently records the first object's voltage of each list,
// then checks result timing, fallback content and index range.
module pdo_cap_select_chk #(
    parameter int VW      = 12,
    parameter int MAX_OBJ = 7,
    parameter int IDX_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              obj_valid,
    input logic              obj_last,
    input logic [VW-1:0]     obj_v_nom,
    input logic              res_valid,
    input logic              res_match,
    input logic [IDX_W-1:0]  res_idx,
    input logic [VW-1:0]     res_volt
);
    logic          at_start;
    logic [VW-1:0] chk_first_v;

    // Capture the first object's nominal voltage of each list.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            at_start    <= 1'b1;
            chk_first_v <= '0;
        end else if (obj_valid) begin
            if (at_start) begin
                chk_first_v <= obj_v_nom;
            end
            at_start <= obj_last;
        end
    end

    assert_result_due_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (obj_valid && obj_last) |=> res_valid);

    assert_result_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(obj_valid && obj_last) |=> !res_valid);

    assert_fallback_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_match) |-> (res_idx == '0));

    assert_fallback_volt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_match) |-> (res_volt == chk_first_v));

    assert_index_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (32'(res_idx) < MAX_OBJ));

endmodule

bind pdo_cap_select pdo_cap_select_chk #(
    .VW      (VW),
    .MAX_OBJ (MAX_OBJ),
    .IDX_W   (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .obj_valid   (obj_valid),
    .obj_last    (obj_last),
    .obj_v_nom   (obj_v_nom),
    .res_valid   (res_valid),
    .res_match   (res_match),
    .res_idx     (res_idx),
    .res_volt    (res_volt)
);

// File: tb/sim_pdo_cap_select.sv
// Bench: behavioural reference model using queues, compared on every falling edge.
module sim_pdo_cap_select;
    localparam int VW = 12, CW = 10, PW = 17, MAX_OBJ = 7, IDX_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] sel_code = '0;
    logic [PW-1:0] req_pw = '0;
    logic obj_valid = 1'b0, obj_last = 1'b0, obj_is_pps = 1'b0;
    logic [VW-1:0] obj_v_nom = '0, obj_v_min = '0, obj_v_max = '0;
    logic [CW-1:0] obj_curr = '0;
    logic res_valid, res_match;
    logic [IDX_W-1:0] res_idx;
    logic [VW-1:0] res_volt;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R11";

    int q_pps[$], q_vn[$], q_vmin[$], q_vmax[$], q_cur[$];
    int m_match, m_idx, m_volt;
    int exp_valid = 0, exp_match = 0, exp_idx = 0, exp_volt = 0;

    always #2.5 clk = ~clk;

    pdo_cap_select #(.VW(VW), .CW(CW), .PW(PW), .MAX_OBJ(MAX_OBJ)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_code(sel_code), .req_pw(req_pw),
        .obj_valid(obj_valid), .obj_last(obj_last), .obj_is_pps(obj_is_pps),
        .obj_v_nom(obj_v_nom), .obj_v_min(obj_v_min), .obj_v_max(obj_v_max),
        .obj_curr(obj_curr), .res_valid(res_valid), .res_match(res_match),
        .res_idx(res_idx), .res_volt(res_volt)
    );

    function automatic int code_volt(input int code);
        case (code)
            0: return 500;
            1: return 900;
            2: return 1500;
            3: return 2000;
            4: return 430;
            5: return 860;
            6: return 1290;
            default: return 1720;
        endcase
    endfunction

    task automatic check_eq(input string tag, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic compare_outputs();
        check_eq("R9", "res_valid", int'(res_valid), exp_valid);
        if (exp_valid != 0 || cur_tag == "R11") begin
            check_eq(cur_tag, "res_match", int'(res_match), exp_match);
            check_eq(cur_tag, "res_idx", int'(res_idx), exp_idx);
            check_eq(cur_tag, "res_volt", int'(res_volt), exp_volt);
        end
    endtask

    task automatic step(input logic v, input logic l, input int p, input int vn,
                        input int vmn, input int vmx, input int cu);
        @(negedge clk);
        compare_outputs();
        obj_valid  = v;
        obj_last   = l;
        obj_is_pps = p[0];
        obj_v_nom  = VW'(vn);
        obj_v_min  = VW'(vmn);
        obj_v_max  = VW'(vmx);
        obj_curr   = CW'(cu);
        if (v && l) begin
            exp_valid = 1;
            exp_match = m_match;
            exp_idx   = m_idx;
            exp_volt  = m_volt;
        end else begin
            exp_valid = 0;
        end
    endtask

    task automatic add_obj(input int p, input int vn, input int vmn, input int vmx, input int cu);
        q_pps.push_back(p); q_vn.push_back(vn); q_vmin.push_back(vmn);
        q_vmax.push_back(vmx); q_cur.push_back(cu);
    endtask

    task automatic run_frame(input int code, input int pw, input string tag);
        int tgt = code_volt(code);
        int best_p = -1, best_f = -1;
        step(1'b0, 1'b0, 0, 0, 0, 0, 0);
        sel_code = 3'(code);
        req_pw   = PW'(pw);
        cur_tag  = tag;
        for (int i = 0; i < q_vn.size() && i < MAX_OBJ; i++) begin
            bit pwr = (q_vn[i] * q_cur[i]) >= (pw * 10);
            if (q_pps[i] == 1 && q_vmin[i] <= tgt && tgt <= q_vmax[i] && pwr) begin
                if (best_p < 0 || q_vn[i] < q_vn[best_p]) best_p = i;
            end
            if (q_pps[i] == 0 && code < 4 && q_vn[i] == tgt && pwr && best_f < 0) best_f = i;
        end
        if (best_p >= 0) begin
            m_match = 1; m_idx = best_p; m_volt = tgt;
        end else if (best_f >= 0) begin
            m_match = 1; m_idx = best_f; m_volt = tgt;
        end else begin
            m_match = 0; m_idx = 0; m_volt = q_vn[0];
        end
        for (int i = 0; i < q_vn.size(); i++) begin
            step(1'b1, i == q_vn.size() - 1, q_pps[i], q_vn[i], q_vmin[i], q_vmax[i], q_cur[i]);
        end
        step(1'b0, 1'b0, 0, 0, 0, 0, 0);
        q_pps.delete(); q_vn.delete(); q_vmin.delete(); q_vmax.delete(); q_cur.delete();
    endtask

    task automatic fixed_36w();
        add_obj(0, 500, 0, 0, 300); add_obj(0, 900, 0, 0, 300); add_obj(0, 1500, 0, 0, 240);
    endtask

    task automatic pps_36w();
        add_obj(1, 500, 330, 590, 300); add_obj(1, 900, 330, 1100, 300);
        add_obj(1, 1500, 330, 1600, 240);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R11: reset state
        repeat (3) step(1'b0, 1'b0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 0, 0, 0, 0, 0);

        // R1: fixed 15 V, power exactly equal
        fixed_36w(); run_frame(2, 36000, "R1");
        // R6: power too high, fallback to the first object
        fixed_36w(); run_frame(2, 45000, "R6");
        // R4: PPS preferred over an equal Fixed candidate
        fixed_36w(); pps_36w(); run_frame(2, 36000, "R4");
        // R7: code 6 gives 12.9 V through PPS
        fixed_36w(); pps_36w(); run_frame(6, 36000, "R7");
        // R8: a Fixed 12.9 V object must not match a PPS-only code
        add_obj(0, 500, 0, 0, 300); add_obj(0, 1290, 0, 0, 500); run_frame(6, 12000, "R8");
        // R5: lowest-voltage PPS wins
        add_obj(1, 1500, 330, 1600, 300); add_obj(1, 900, 330, 1100, 300);
        add_obj(1, 500, 330, 590, 300); run_frame(0, 10000, "R5");
        // R5: equal candidates, lower index wins
        add_obj(0, 500, 0, 0, 300); add_obj(1, 900, 330, 1100, 300);
        add_obj(1, 900, 330, 1100, 300); run_frame(1, 20000, "R5");
        // R2: inclusive minimum
        add_obj(0, 500, 0, 0, 300); add_obj(1, 1000, 900, 1100, 300); run_frame(1, 20000, "R2");
        // R2: maximum one step below the request
        add_obj(0, 500, 0, 0, 300); add_obj(1, 800, 330, 899, 300); run_frame(1, 20000, "R2");
        // R2: inclusive maximum
        add_obj(0, 500, 0, 0, 300); add_obj(1, 800, 330, 900, 300); run_frame(1, 20000, "R2");
        // R3: power uses the nominal voltage, exact boundary
        add_obj(0, 500, 0, 0, 300); add_obj(1, 500, 330, 590, 240); run_frame(4, 12000, "R3");
        // R3: one current step short
        add_obj(0, 500, 0, 0, 300); add_obj(1, 500, 330, 590, 239); run_frame(4, 12000, "R3");
        // R10: match at index 6 is counted
        for (int i = 0; i < 6; i++) add_obj(0, 500, 0, 0, 300);
        add_obj(0, 900, 0, 0, 300); run_frame(1, 20000, "R10");
        // R10: match at the eighth object is ignored
        for (int i = 0; i < 7; i++) add_obj(0, 500, 0, 0, 300);
        add_obj(0, 900, 0, 0, 300); run_frame(1, 20000, "R10");
        // R9: single-object list, then idle
        add_obj(0, 2000, 0, 0, 500); run_frame(3, 60000, "R9");
        repeat (3) step(1'b0, 1'b0, 0, 0, 0, 0, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule